// File: doc/BRIEF.md
# Four-Term Weighted Score Accumulator

This block combines four unsigned 8-bit scores into one weighted total. The score on `score_a` carries weight 1, `score_b` weight 2, `score_c` weight 3 and `score_d` weight 4. The total is reported in tenths, so it equals the sum with weights 0.1, 0.2, 0.3 and 0.4 multiplied by ten. For example, 810 stands for 81.0. Integer weights keep the arithmetic exact.

A build-time parameter `SPATIAL` picks one of two datapaths behind the same ports.

The sequential build (`SPATIAL = 0`) has one weight multiplier, one adder, a product register and an accumulator, and a four-state machine steps them:
- `ST_IDLE` holds `in_ready` high. It takes the *accept* transition to `ST_MUL` when `in_valid` is high. On that edge it latches the scores, clears the accumulator and points the term index at the first term.
- `ST_MUL` stores the current term's product and takes the *multiply-done* transition to `ST_ADD`.
- `ST_ADD` adds the product into the accumulator and advances the index. It takes the *next-term* transition back to `ST_MUL`, or the *last-term* transition to `ST_DONE` after the fourth term.
- `ST_DONE` shows the result for one cycle and takes the *retire* transition to `ST_IDLE`.

The parallel build (`SPATIAL = 1`) is different. It has a separate multiplier for each term, feeding a registered stage, and an adder tree feeding a second registered stage. It does the whole calculation every cycle and takes a new score set on every clock.

Top module: `weighted_sum_unit`

## Requirements
- R1: When `out_valid` is high, `out_sum` equals `score_a + 2*score_b + 3*score_c + 4*score_d` for the score set that was accepted.
- R2: `out_sum` is 12 bits wide. The largest total, 2550 (all scores 255), comes out exactly with no wrap.
- R3: Reset is asynchronous and active low. While reset is low and in the cycle after it, `out_valid` is 0 and `in_ready` is 1 in both builds. This includes a reset applied in the middle of a sequential computation.
- R4: Sequential build: `in_ready` is 1 only in `ST_IDLE`. From the cycle after an accept until the result cycle is over, it stays 0.
- R5: Sequential build: `out_valid` is high for exactly one cycle, the cycle after the 8th rising edge following the accept edge (four multiply steps, then four add steps interleaved).
- R6: Sequential build: neither `in_valid` nor the score inputs have any effect while busy. The reported result belongs to the accepted set.
- R7: Sequential build: the accumulator starts from zero for every accepted set, so a result does not depend on the set before it.
- R8: Parallel build: `in_ready` is 1 in every cycle out of reset.
- R9: Parallel build: a set presented with `in_valid` high on a rising edge appears with `out_valid` high right after the second rising edge that follows. Sets presented on consecutive edges come out on consecutive cycles, in the same order.
- R10: Parallel build: an edge with `in_valid` low gives a cycle with `out_valid` low two edges later.
- R11: Both builds give the same `out_sum` for the same score set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Score set on the score inputs is offered |
| in_ready | output | 1 | Block takes the offered set on this edge |
| score_a | input | 8 | First score, weight 1 |
| score_b | input | 8 | Second score, weight 2 |
| score_c | input | 8 | Third score, weight 3 |
| score_d | input | 8 | Fourth score, weight 4 |
| out_valid | output | 1 | `out_sum` holds a finished total |
| out_sum | output | 12 | Weighted total in tenths |

## Verification
In the sequential build, a wrong state or index shows at the ports within one transaction:
- A skipped or repeated `ST_MUL`/`ST_ADD` step moves the `out_valid` pulse off the eighth cycle.
- A wrongly advanced term index gives a sum with one weight swapped.
- An accumulator left uncleared shows up as soon as a small set follows a large one.

In the parallel build, a wrong or missing stage register shifts `out_valid` and the sum stream by a cycle, which the next streamed set reveals. Running both builds on the same random sets exposes any disagreement in the first differing total.

// File: rtl/ws_pkg.sv
package ws_pkg;

    localparam int SCORE_W = 8;
    localparam int NTERMS  = 4;
    localparam int WGT_SUM = NTERMS * (NTERMS + 1) / 2;
    localparam int MAX_SUM = ((1 << SCORE_W) - 1) * WGT_SUM;
    localparam int RES_W   = $clog2(MAX_SUM + 1);
    localparam int WGT_W   = $clog2(NTERMS + 1);
    localparam int PROD_W  = SCORE_W + WGT_W;
    localparam int IDX_W   = $clog2(NTERMS);

    typedef logic [SCORE_W-1:0] score_t;
    typedef score_t [NTERMS-1:0] score_vec_t;
    typedef logic [PROD_W-1:0]  prod_t;
    typedef logic [RES_W-1:0]   sum_t;
    typedef logic [WGT_W-1:0]   wgt_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MUL,
        ST_ADD,
        ST_DONE
    } seq_state_e;

    // Weight of term i in tenths: term 0 -> 1, term 3 -> 4.
    function automatic wgt_t term_weight(input int i);
        return wgt_t'(i + 1);
    endfunction

    // Full weighted total of a score set, in tenths.
    function automatic sum_t weighted_total(input score_vec_t s);
        sum_t acc;
        acc = '0;
        for (int i = 0; i < NTERMS; i++) begin
            acc = acc + sum_t'(s[i]) * sum_t'(term_weight(i));
        end
        return acc;
    endfunction

endpackage

// File: rtl/ws_weight_mul.sv
module ws_weight_mul
    import ws_pkg::*;
(
    input  score_t score,
    input  wgt_t   weight,
    output prod_t  product
);

    assign product = prod_t'(score) * prod_t'(weight);

endmodule

// File: rtl/ws_add_tree.sv
module ws_add_tree
    import ws_pkg::*;
#(
    parameter int N = NTERMS
)(
    input  prod_t [N-1:0] terms,
    output sum_t          total
);

    localparam int HALF = (N + 1) / 2;

    sum_t [HALF-1:0] pair_sum;

    // First level: pairwise adders.
    for (genvar p = 0; p < HALF; p++) begin : g_pair
        if (2 * p + 1 < N) begin : g_two
            assign pair_sum[p] = sum_t'(terms[2*p]) + sum_t'(terms[2*p+1]);
        end else begin : g_one
            assign pair_sum[p] = sum_t'(terms[2*p]);
        end
    end

    // Second level: combine the pair sums.
    always_comb begin
        total = '0;
        for (int p = 0; p < HALF; p++) begin
            total = total + pair_sum[p];
        end
    end

endmodule

// File: rtl/ws_temporal.sv
module ws_temporal
    import ws_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  score_vec_t scores,
    output logic       out_valid,
    output sum_t       out_sum
);

    localparam idx_t LAST_IDX = idx_t'(NTERMS - 1);

    seq_state_e state, state_nx;
    idx_t       idx;
    score_vec_t held;
    prod_t      tmp;
    sum_t       acc;
    prod_t      mul_out;

    ws_weight_mul u_mul (
        .score   (held[idx]),
        .weight  (term_weight(int'(idx))),
        .product (mul_out)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid) state_nx = ST_MUL;
            ST_MUL:  state_nx = ST_ADD;
            ST_ADD:  state_nx = (idx == LAST_IDX) ? ST_DONE : ST_MUL;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Datapath: operand latch, product register, accumulator, term index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
            tmp  <= '0;
            acc  <= '0;
            idx  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        held <= scores;
                        acc  <= '0;
                        idx  <= '0;
                    end
                end
                ST_MUL: tmp <= mul_out;
                ST_ADD: begin
                    acc <= acc + sum_t'(tmp);
                    idx <= idx + idx_t'(1);
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        in_ready  = (state == ST_IDLE);
        out_valid = (state == ST_DONE);
        out_sum   = acc;
    end

endmodule

// File: rtl/ws_spatial.sv
module ws_spatial
    import ws_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  score_vec_t scores,
    output logic       out_valid,
    output sum_t       out_sum
);

    prod_t [NTERMS-1:0] prod_c;
    prod_t [NTERMS-1:0] prod_q;
    logic               stg1_valid;
    sum_t               tree_sum;
    sum_t               sum_q;
    logic               stg2_valid;

    for (genvar t = 0; t < NTERMS; t++) begin : g_term
        ws_weight_mul u_mul (
            .score   (scores[t]),
            .weight  (term_weight(t)),
            .product (prod_c[t])
        );
    end

    ws_add_tree #(.N(NTERMS)) u_tree (
        .terms (prod_q),
        .total (tree_sum)
    );

    // Multiply stage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q     <= '0;
            stg1_valid <= 1'b0;
        end else begin
            prod_q     <= prod_c;
            stg1_valid <= in_valid;
        end
    end

    // Adder-tree stage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q      <= '0;
            stg2_valid <= 1'b0;
        end else begin
            sum_q      <= tree_sum;
            stg2_valid <= stg1_valid;
        end
    end

    always_comb begin
        in_ready  = 1'b1;
        out_valid = stg2_valid;
        out_sum   = sum_q;
    end

endmodule

// File: rtl/weighted_sum_unit.sv
module weighted_sum_unit
    import ws_pkg::*;
#(
    parameter bit SPATIAL = 1'b0
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       score_a,
    input  logic [7:0]       score_b,
    input  logic [7:0]       score_c,
    input  logic [7:0]       score_d,
    output logic             out_valid,
    output logic [RES_W-1:0] out_sum
);

    score_vec_t scores;

    always_comb begin
        scores[0] = score_a;
        scores[1] = score_b;
        scores[2] = score_c;
        scores[3] = score_d;
    end

    if (SPATIAL) begin : g_spatial
        ws_spatial u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid),
            .in_ready  (in_ready),
            .scores    (scores),
            .out_valid (out_valid),
            .out_sum   (out_sum)
        );
    end else begin : g_temporal
        ws_temporal u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid),
            .in_ready  (in_ready),
            .scores    (scores),
            .out_valid (out_valid),
            .out_sum   (out_sum)
        );
    end

endmodule

// File: rtl/ws_checker.sv
module ws_checker
    import ws_pkg::*;
#(
    parameter bit SPATIAL = 1'b0
)(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [7:0]       score_a,
    input logic [7:0]       score_b,
    input logic [7:0]       score_c,
    input logic [7:0]       score_d,
    input logic             out_valid,
    input logic [RES_W-1:0] out_sum
);

    score_vec_t cur;
    always_comb begin
        cur[0] = score_a;
        cur[1] = score_b;
        cur[2] = score_c;
        cur[3] = score_d;
    end

    // R2: total never exceeds the all-255 maximum
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sum <= sum_t'(MAX_SUM)));

    if (SPATIAL) begin : g_par
        logic [1:0] vhist;
        sum_t       exp0, exp1;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vhist <= '0;
                exp0  <= '0;
                exp1  <= '0;
            end else begin
                vhist <= {vhist[0], in_valid};
                exp0  <= weighted_total(cur);
                exp1  <= exp0;
            end
        end

        // R8: always ready
        a_r8_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
            in_ready);

        // R9, R10: valid follows input valid two edges later
        a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == vhist[1]);

        // R1: sum matches set from two edges earlier
        a_r1_sum_par: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_sum == exp1));
    end else begin : g_seq
        logic [3:0] age;
        sum_t       exp_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                age   <= '0;
                exp_q <= '0;
            end else if (in_valid && in_ready) begin
                age   <= 4'd1;
                exp_q <= weighted_total(cur);
            end else if (out_valid) begin
                age   <= '0;
            end else if (age != 4'd0) begin
                age   <= age + 4'd1;
            end
        end

        // R4: accept closes the input
        a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_ready) |=> !in_ready);

        // R4: no ready during the result cycle
        a_r4_no_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> !in_ready);

        // R5: one-cycle pulse
        a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |=> !out_valid);

        // R5: pulse comes eight edges after accept
        a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (age == 4'd9));

        // R1, R6: total belongs to the accepted set
        a_r1_sum_seq: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_sum == exp_q));
    end

endmodule

bind weighted_sum_unit ws_checker #(.SPATIAL(SPATIAL)) u_chk (.*);

// File: tb/sim_weighted_sum_unit.sv
module sim_weighted_sum_unit;

    localparam time PERIOD = 10ns;
    localparam int  NV     = 9;

    typedef struct packed {
        logic [7:0]  a;
        logic [7:0]  b;
        logic [7:0]  c;
        logic [7:0]  d;
        logic [11:0] e;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{8'd255, 8'd255, 8'd255, 8'd255, 12'd2550},
        '{8'd0,   8'd0,   8'd0,   8'd0,   12'd0},
        '{8'd10,  8'd0,   8'd0,   8'd0,   12'd10},
        '{8'd0,   8'd10,  8'd0,   8'd0,   12'd20},
        '{8'd0,   8'd0,   8'd10,  8'd0,   12'd30},
        '{8'd0,   8'd0,   8'd0,   8'd10,  12'd40},
        '{8'd80,  8'd90,  8'd70,  8'd85,  12'd810},
        '{8'd1,   8'd2,   8'd3,   8'd4,   12'd30},
        '{8'd200, 8'd50,  8'd100, 8'd150, 12'd1200}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        t_valid = 1'b0, s_valid = 1'b0;
    logic [7:0]  sa = '0, sb = '0, sc = '0, sd = '0;
    logic        t_ready, t_ov, s_ready, s_ov;
    logic [11:0] t_sum, s_sum;

    int errors = 0;
    int checks = 0;

    always #(PERIOD/2) clk = ~clk;

    weighted_sum_unit #(.SPATIAL(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(t_valid), .in_ready(t_ready),
        .score_a(sa), .score_b(sb), .score_c(sc), .score_d(sd),
        .out_valid(t_ov), .out_sum(t_sum)
    );

    weighted_sum_unit #(.SPATIAL(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_ready(s_ready),
        .score_a(sa), .score_b(sb), .score_c(sc), .score_d(sd),
        .out_valid(s_ov), .out_sum(s_sum)
    );

    function automatic int ref_sum(input int a, input int b, input int c, input int d);
        return a + 2*b + 3*c + 4*d;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] a, b, c, d);
        sa = a; sb = b; sc = c; sd = d;
    endtask

    // Sequential build: one transaction, optional busy-time noise (R6).
    task automatic run_seq(input logic [7:0] a, b, c, d, input int exp,
                           input bit noise, output int got);
        got = -1;
        @(negedge clk);
        put(a, b, c, d);
        t_valid = 1'b1;
        for (int k = 0; k <= 9; k++) begin
            @(negedge clk);
            if (k == 0) begin
                check(t_ready == 1'b0, "R4 ready low after accept", t_ready, 0);
                if (noise) put(8'd255, 8'd255, 8'd255, 8'd255);
                else t_valid = 1'b0;
            end
            if (k == 8) t_valid = 1'b0;
            if (k < 8) begin
                if (t_ov) check(1'b0, "R5 early valid", k, 8);
                if (k > 0 && t_ready) check(1'b0, "R4 ready while busy", k, 0);
            end else if (k == 8) begin
                check(t_ov == 1'b1, "R5 valid on eighth cycle", t_ov, 1);
                check(t_sum == 12'(exp), "R1 sequential sum", t_sum, exp);
                got = t_sum;
            end else begin
                check(t_ov == 1'b0, "R5 single-cycle pulse", t_ov, 0);
                check(t_ready == 1'b1, "R4 ready back in idle", t_ready, 1);
            end
        end
    endtask

    // Parallel build: single set, result two edges later.
    task automatic run_par(input logic [7:0] a, b, c, d, output int got);
        @(negedge clk);
        put(a, b, c, d);
        s_valid = 1'b1;
        @(negedge clk);
        s_valid = 1'b0;
        @(negedge clk);
        check(s_ov == 1'b1, "R9 parallel valid", s_ov, 1);
        got = s_sum;
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int got, gp;
        // Reset state (R3).
        repeat (3) @(negedge clk);
        check(t_ov == 1'b0 && s_ov == 1'b0, "R3 valid low in reset", t_ov | s_ov, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(t_ready == 1'b1, "R3 sequential ready after reset", t_ready, 1);
        check(s_ready == 1'b1, "R3 parallel ready after reset", s_ready, 1);
        check(t_ov == 1'b0 && s_ov == 1'b0, "R3 valid low after reset", t_ov | s_ov, 0);

        // Table walk on the sequential build (R1, R2, R7 from the order).
        for (int i = 0; i < NV; i++) begin
            run_seq(VECS[i].a, VECS[i].b, VECS[i].c, VECS[i].d, int'(VECS[i].e), 1'b0, got);
            if (i == 0) check(got == 2550, "R2 full-scale total", got, 2550);
            if (i == 1) check(got == 0, "R7 cleared accumulator", got, 0);
        end

        // Table streamed back to back on the parallel build (R8, R9).
        for (int cyc = 0; cyc < NV + 2; cyc++) begin
            @(negedge clk);
            check(s_ready == 1'b1, "R8 always ready", s_ready, 1);
            if (cyc >= 2) begin
                check(s_ov == 1'b1, "R9 streamed valid", s_ov, 1);
                check(s_sum == VECS[cyc-2].e, "R9 streamed sum in order", s_sum, int'(VECS[cyc-2].e));
            end
            if (cyc < NV) begin
                put(VECS[cyc].a, VECS[cyc].b, VECS[cyc].c, VECS[cyc].d);
                s_valid = 1'b1;
            end else begin
                s_valid = 1'b0;
            end
        end

        // Bubble (R10).
        @(negedge clk);
        put(8'd3, 8'd3, 8'd3, 8'd3);
        s_valid = 1'b1;
        @(negedge clk);
        s_valid = 1'b0;
        put(8'd9, 8'd9, 8'd9, 8'd9);
        @(negedge clk);
        check(s_ov == 1'b1 && s_sum == 12'd30, "R10 set before bubble", s_sum, 30);
        @(negedge clk);
        check(s_ov == 1'b0, "R10 bubble gives no valid", s_ov, 0);

        // Busy-time noise ignored (R6).
        run_seq(8'd4, 8'd5, 8'd6, 8'd7, ref_sum(4, 5, 6, 7), 1'b1, got);
        check(got == ref_sum(4, 5, 6, 7), "R6 busy inputs ignored", got, ref_sum(4, 5, 6, 7));

        // Random sets, both builds against reference and each other (R11).
        for (int n = 0; n < 24; n++) begin
            logic [7:0] ra, rb, rc, rd;
            ra = 8'($urandom); rb = 8'($urandom); rc = 8'($urandom); rd = 8'($urandom);
            run_seq(ra, rb, rc, rd, ref_sum(ra, rb, rc, rd), 1'b0, got);
            run_par(ra, rb, rc, rd, gp);
            check(gp == ref_sum(ra, rb, rc, rd), "R1 parallel random sum", gp, ref_sum(ra, rb, rc, rd));
            check(gp == got, "R11 builds agree", gp, got);
        end

        // Reset during a sequential computation (R3).
        @(negedge clk);
        put(8'd50, 8'd50, 8'd50, 8'd50);
        t_valid = 1'b1;
        @(negedge clk);
        t_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(t_ready == 1'b1 && t_ov == 1'b0, "R3 mid-run reset idles", t_ready, 1);
        rst_n = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (t_ov) check(1'b0, "R3 no stale result after reset", t_ov, 0);
        end
        run_seq(8'd1, 8'd1, 8'd1, 8'd1, 10, 1'b0, got);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule